// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block sequences a processor core through four power states: running, halted-awaiting-wake, stop-clock granted, and sleep. It watches a halt-executed pulse, five wake requests (system-management interrupt, bus initialisation, init, non-maskable interrupt and maskable interrupt), the end of a system-management handler, and two level-sensitive request pins: one that asks the core to stop its clocks and one that asks for sleep. From these it drives the state code, a request asking the bus unit to issue a stop-grant acknowledge cycle, an enable for the core clocks, an enable for accepting interrupts and snoops, and the select of a shared output pin that carries either the floating-point error indication or the pending-break indication.

The stop-clock handshake has two phases. The controller first raises its acknowledge request and holds it until the bus unit reports the response phase of that cycle. It then counts a fixed number of bus clocks and only then enters the stop-grant state. Sleep can be reached only from stop-grant. The shared pin shows the pending-break function while the acknowledge is outstanding and for a parameterised window after the stop-clock pin is released.

Top module: `psc_power_ctrl`

## Requirements
- R1: While and right after reset, `pstate` is 0 (Normal), `ack_req` is 0, `core_clk_en` and `snoop_irq_en` are 1 and `pin_sel_break` is 0. State codes are 0 Normal, 1 AutoHALT, 2 Stop-Grant, 3 Sleep.
- R2: A `halt_exec` pulse in Normal gives `pstate` 1 at the next clock edge; in any other state it has no effect.
- R3: In AutoHALT, any one of `smi_req`, `binit_req`, `init_req`, `nmi_req`, `intr_req` gives `pstate` 0 at the next edge; in Normal these requests leave the state at 0.
- R4: An `smi_rsm` pulse in Normal moves to AutoHALT when `rsm_to_halt` is 1 and stays in Normal when it is 0.
- R5: With `stpclk_req` high in Normal or AutoHALT, `ack_req` is 1 from the first edge after it is sampled until the edge that samples `rsp_phase` high, and 0 after that edge.
- R6: Stop-Grant (2) is entered exactly `SG_DELAY` clock edges (default 20) after the edge that samples `rsp_phase`, and not earlier.
- R7: Dropping `stpclk_req` before Stop-Grant is reached cancels the handshake: `ack_req` returns to 0 and the state never becomes 2.
- R8: `slp_req` in Stop-Grant gives Sleep (3) at the next edge; in Normal or AutoHALT it has no effect.
- R9: `core_clk_en` and `snoop_irq_en` are 0 in Sleep and 1 in every other state; wake and halt inputs are ignored in Sleep and Stop-Grant.
- R10: Releasing `slp_req` in Sleep returns to Stop-Grant; releasing `stpclk_req` in Stop-Grant returns to Normal.
- R11: `pin_sel_break` is 1 exactly while `ack_req` is 1, and for `BRK_WIN` cycles (default 4) starting at the first edge after `stpclk_req` is sampled low following a high sample; it is 0 otherwise.
- R12: Asserting `rst_n` low forces Normal at once from any state, Sleep included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_exec | input | 1 | Pulse: halt instruction retired |
| smi_req | input | 1 | System-management interrupt request |
| binit_req | input | 1 | Bus initialisation request |
| init_req | input | 1 | Init request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| intr_req | input | 1 | Maskable interrupt request |
| smi_rsm | input | 1 | Pulse: system-management handler finished |
| rsm_to_halt | input | 1 | Resume target flag: 1 AutoHALT, 0 Normal |
| stpclk_req | input | 1 | Stop-clock request level, active high |
| slp_req | input | 1 | Sleep request level, active high |
| rsp_phase | input | 1 | Response phase of the acknowledge cycle seen |
| pstate | output | 2 | Current power state code |
| ack_req | output | 1 | Request to issue stop-grant acknowledge cycle |
| core_clk_en | output | 1 | Core internal clock enable |
| snoop_irq_en | output | 1 | Interrupt and snoop acceptance enable |
| pin_sel_break | output | 1 | Shared pin select: 1 pending-break, 0 error |

## Verification
The hardest condition to reach is the exact edge at which Stop-Grant begins, because it depends on when the response phase arrives, which is decoupled from the stop-clock assertion by an arbitrary bus latency. The bench sweeps that latency over several values, from both Normal and AutoHALT, and walks the state every cycle of the counting window to show the transition lands on the twentieth edge and no earlier. It also drops the stop-clock pin in the middle of the window to reach the cancelled-handshake path, and releases it from Stop-Grant to time the pending-break window cycle by cycle.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_HALT  = 2'd1,
        PS_GRANT = 2'd2,
        PS_SLEEP = 2'd3
    } pstate_e;

    typedef enum logic [1:0] {
        AQ_IDLE = 2'd0,
        AQ_REQ  = 2'd1,
        AQ_WAIT = 2'd2
    } ackph_e;

endpackage

// File: rtl/psc_ack_seq.sv
module psc_ack_seq
    import psc_pkg::*;
#(
    parameter int SG_DELAY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stpclk,
    input  logic rsp_phase,
    input  logic allow,
    output logic ack_req,
    output logic sg_go
);
    localparam int CW = (SG_DELAY < 2) ? 1 : $clog2(SG_DELAY + 1);
    localparam logic [CW-1:0] LOAD = CW'(SG_DELAY - 1);

    typedef struct packed {
        ackph_e        ph;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        sg_go = 1'b0;
        if (!stpclk) begin
            seq_d.ph  = AQ_IDLE;
            seq_d.cnt = '0;
        end else begin
            unique case (seq_q.ph)
                AQ_IDLE: if (allow) seq_d.ph = AQ_REQ;
                AQ_REQ: if (rsp_phase) begin
                    seq_d.ph  = AQ_WAIT;
                    seq_d.cnt = LOAD;
                end
                AQ_WAIT: begin
                    if (seq_q.cnt == '0) begin
                        sg_go     = 1'b1;
                        seq_d.ph  = AQ_IDLE;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
                default: seq_d.ph = AQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ph  <= AQ_IDLE;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ack_req = (seq_q.ph == AQ_REQ);

endmodule

// File: rtl/psc_break_win.sv
module psc_break_win #(
    parameter int BRK_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stpclk,
    input  logic ack_pending,
    output logic sel_break
);
    localparam int WW = (BRK_WIN < 1) ? 1 : $clog2(BRK_WIN + 1);

    typedef struct packed {
        logic          stp;
        logic [WW-1:0] win;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d     = w_q;
        w_d.stp = stpclk;
        if (w_q.stp && !stpclk) begin
            w_d.win = WW'(BRK_WIN);
        end else if (w_q.win != '0) begin
            w_d.win = w_q.win - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.stp <= 1'b0;
            w_q.win <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign sel_break = ack_pending || (w_q.win != '0);

endmodule

// File: rtl/psc_state_fsm.sv
module psc_state_fsm
    import psc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    halt_exec,
    input  logic    wake_any,
    input  logic    smi_rsm,
    input  logic    rsm_to_halt,
    input  logic    stpclk,
    input  logic    slp_req,
    input  logic    sg_go,
    output pstate_e state,
    output logic    seq_allow,
    output logic    clk_en,
    output logic    snp_en
);
    typedef struct packed {
        pstate_e st;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            PS_RUN: begin
                if (sg_go)                         f_d.st = PS_GRANT;
                else if (halt_exec)                f_d.st = PS_HALT;
                else if (smi_rsm && rsm_to_halt)   f_d.st = PS_HALT;
            end
            PS_HALT: begin
                if (sg_go)         f_d.st = PS_GRANT;
                else if (wake_any) f_d.st = PS_RUN;
            end
            PS_GRANT: begin
                if (!stpclk)      f_d.st = PS_RUN;
                else if (slp_req) f_d.st = PS_SLEEP;
            end
            PS_SLEEP: begin
                if (!slp_req) f_d.st = PS_GRANT;
            end
            default: f_d.st = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q.st <= PS_RUN;
        else        f_q <= f_d;
    end

    assign state     = f_q.st;
    assign seq_allow = (f_q.st == PS_RUN) || (f_q.st == PS_HALT);
    assign clk_en    = (f_q.st != PS_SLEEP);
    assign snp_en    = (f_q.st != PS_SLEEP);

endmodule

// File: rtl/psc_power_ctrl.sv
module psc_power_ctrl
    import psc_pkg::*;
#(
    parameter int SG_DELAY = 20,
    parameter int BRK_WIN  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_exec,
    input  logic       smi_req,
    input  logic       binit_req,
    input  logic       init_req,
    input  logic       nmi_req,
    input  logic       intr_req,
    input  logic       smi_rsm,
    input  logic       rsm_to_halt,
    input  logic       stpclk_req,
    input  logic       slp_req,
    input  logic       rsp_phase,
    output logic [1:0] pstate,
    output logic       ack_req,
    output logic       core_clk_en,
    output logic       snoop_irq_en,
    output logic       pin_sel_break
);
    pstate_e st;
    logic    allow;
    logic    go;
    logic    wake;

    assign wake = smi_req | binit_req | init_req | nmi_req | intr_req;

    psc_state_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_exec  (halt_exec),
        .wake_any   (wake),
        .smi_rsm    (smi_rsm),
        .rsm_to_halt(rsm_to_halt),
        .stpclk     (stpclk_req),
        .slp_req    (slp_req),
        .sg_go      (go),
        .state      (st),
        .seq_allow  (allow),
        .clk_en     (core_clk_en),
        .snp_en     (snoop_irq_en)
    );

    psc_ack_seq #(.SG_DELAY(SG_DELAY)) i_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .stpclk   (stpclk_req),
        .rsp_phase(rsp_phase),
        .allow    (allow),
        .ack_req  (ack_req),
        .sg_go    (go)
    );

    psc_break_win #(.BRK_WIN(BRK_WIN)) i_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .stpclk     (stpclk_req),
        .ack_pending(ack_req),
        .sel_break  (pin_sel_break)
    );

    assign pstate = st;

endmodule

// File: rtl/psc_power_ctrl_chk.sv
module psc_power_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stpclk_req,
    input logic       halt_exec,
    input logic [1:0] pstate,
    input logic       ack_req,
    input logic       core_clk_en,
    input logic       pin_sel_break
);
    // R8
    sleep_only_from_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'd3) |-> ($past(pstate) == 2'd2 || $past(pstate) == 2'd3));

    // R2
    halt_only_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'd1 && $past(pstate) != 2'd1) |-> ($past(pstate) == 2'd0));

    // R6
    grant_needs_stpclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'd2 && $past(pstate) != 2'd2 && $past(pstate) != 2'd3)
            |-> ($past(stpclk_req) && !ack_req));

    // R9
    clk_off_means_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> ($past(pstate) == 2'd2));

    // R11
    ack_shows_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> pin_sel_break);

    // R5
    ack_only_when_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> (pstate == 2'd0 || pstate == 2'd1));

    logic unused_ok;
    assign unused_ok = halt_exec;

endmodule

bind psc_power_ctrl psc_power_ctrl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stpclk_req   (stpclk_req),
    .halt_exec    (halt_exec),
    .pstate       (pstate),
    .ack_req      (ack_req),
    .core_clk_en  (core_clk_en),
    .pin_sel_break(pin_sel_break)
);

// File: tb/test_psc_power_ctrl.sv
module test_psc_power_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SG_DELAY   = 20;
    localparam int BRK_WIN    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_exec = 1'b0;
    logic [4:0] wake = '0;
    logic       smi_rsm = 1'b0;
    logic       rsm_to_halt = 1'b0;
    logic       stpclk_req = 1'b0;
    logic       slp_req = 1'b0;
    logic       rsp_phase = 1'b0;
    logic [1:0] pstate;
    logic       ack_req;
    logic       core_clk_en;
    logic       snoop_irq_en;
    logic       pin_sel_break;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psc_power_ctrl #(.SG_DELAY(SG_DELAY), .BRK_WIN(BRK_WIN)) i_psc_power_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec),
        .smi_req(wake[0]), .binit_req(wake[1]), .init_req(wake[2]),
        .nmi_req(wake[3]), .intr_req(wake[4]),
        .smi_rsm(smi_rsm), .rsm_to_halt(rsm_to_halt),
        .stpclk_req(stpclk_req), .slp_req(slp_req), .rsp_phase(rsp_phase),
        .pstate(pstate), .ack_req(ack_req), .core_clk_en(core_clk_en),
        .snoop_irq_en(snoop_irq_en), .pin_sel_break(pin_sel_break)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic go_halt();
        halt_exec = 1'b1; step(); halt_exec = 1'b0;
    endtask

    // drive stop-clock, wait d cycles with ack pending, give response, count to grant
    task automatic reach_grant(input int d, input int from_st);
        stpclk_req = 1'b1; step();
        chk("R5 ack raised", ack_req, 1);
        chk("R11 break during ack", pin_sel_break, 1);
        chk("R5 state kept", pstate, from_st);
        for (int k = 0; k < d; k++) begin
            step();
            chk("R5 ack held", ack_req, 1);
        end
        rsp_phase = 1'b1; step(); rsp_phase = 1'b0;
        chk("R5 ack dropped", ack_req, 0);
        chk("R11 break off after ack", pin_sel_break, 0);
        for (int k = 1; k < SG_DELAY; k++) begin
            step();
            chk("R6 not yet grant", int'(pstate == 2'd2), 0);
        end
        step();
        chk("R6 grant on time", pstate, 2);
    endtask

    task automatic leave_grant();
        stpclk_req = 1'b0;
        for (int k = 1; k <= BRK_WIN; k++) begin
            step();
            if (k == 1) chk("R10 back to normal", pstate, 0);
            chk("R11 break window", pin_sel_break, 1);
        end
        step();
        chk("R11 window closed", pin_sel_break, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 reset state", pstate, 0);
        rst_n = 1'b1; step();
        chk("R1 state", pstate, 0);
        chk("R1 ack", ack_req, 0);
        chk("R1 clk_en", core_clk_en, 1);
        chk("R1 snoop", snoop_irq_en, 1);
        chk("R1 break", pin_sel_break, 0);

        // R2 / R3: every wake source, and wakes ignored in Normal
        for (int i = 0; i < 5; i++) begin
            wake = 5'(1 << i); step(); wake = '0;
            chk("R3 wake in normal", pstate, 0);
            go_halt();
            chk("R2 halt", pstate, 1);
            go_halt();
            chk("R2 halt in halt", pstate, 1);
            wake = 5'(1 << i); step(); wake = '0;
            chk("R3 wake", pstate, 0);
        end

        // R4: resume target
        rsm_to_halt = 1'b0; smi_rsm = 1'b1; step(); smi_rsm = 1'b0;
        chk("R4 resume normal", pstate, 0);
        rsm_to_halt = 1'b1; smi_rsm = 1'b1; step(); smi_rsm = 1'b0; rsm_to_halt = 1'b0;
        chk("R4 resume halt", pstate, 1);
        wake = 5'b00001; step(); wake = '0;

        // R8: sleep ignored outside grant
        slp_req = 1'b1; step(); step();
        chk("R8 sleep ignored normal", pstate, 0);
        slp_req = 1'b0; go_halt();
        slp_req = 1'b1; step(); step();
        chk("R8 sleep ignored halt", pstate, 1);
        slp_req = 1'b0;
        wake = 5'b10000; step(); wake = '0;

        // R5 / R6: response latency sweep from Normal and AutoHALT
        for (int d = 0; d < 6; d += 2) begin
            reach_grant(d, 0);
            halt_exec = 1'b1; wake = 5'b11111; step(); halt_exec = 1'b0; wake = '0;
            chk("R9 inputs ignored in grant", pstate, 2);
            leave_grant();
            go_halt();
            reach_grant(d + 1, 1);
            leave_grant();
        end

        // R8 / R9 / R10: sleep round trip
        reach_grant(1, 0);
        slp_req = 1'b1; step();
        chk("R8 sleep entered", pstate, 3);
        chk("R9 clk off", core_clk_en, 0);
        chk("R9 snoop off", snoop_irq_en, 0);
        wake = 5'b11111; halt_exec = 1'b1; step(); wake = '0; halt_exec = 1'b0;
        chk("R9 sleep holds", pstate, 3);
        slp_req = 1'b0; step();
        chk("R10 sleep to grant", pstate, 2);
        chk("R9 clk back", core_clk_en, 1);
        leave_grant();

        // R7: cancel while ack pending, then cancel while counting
        stpclk_req = 1'b1; step();
        chk("R7 ack up", ack_req, 1);
        stpclk_req = 1'b0; step();
        chk("R7 ack cancelled", ack_req, 0);
        chk("R7 state", pstate, 0);
        for (int k = 0; k < BRK_WIN + 1; k++) step();
        stpclk_req = 1'b1; step();
        rsp_phase = 1'b1; step(); rsp_phase = 1'b0;
        for (int k = 0; k < 5; k++) step();
        stpclk_req = 1'b0;
        for (int k = 0; k < SG_DELAY + 4; k++) begin
            step();
            chk("R7 no grant", int'(pstate == 2'd2), 0);
        end
        chk("R7 ack idle", ack_req, 0);

        // R12: reset from Sleep
        reach_grant(0, 0);
        slp_req = 1'b1; step();
        chk("R12 in sleep", pstate, 3);
        #2 rst_n = 1'b0; #1;
        chk("R12 async reset", pstate, 0);
        chk("R12 clk_en", core_clk_en, 1);
        slp_req = 1'b0; stpclk_req = 1'b0;
        step(); rst_n = 1'b1; step();
        chk("R12 after reset", pstate, 0);
        chk("R1 break after reset", pin_sel_break, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule